// File: doc/BRIEF.md
# Atomic Cache-Line Lock Unit

This unit sits beside a private data cache and makes atomic read-modify-write operations indivisible as other agents see them. The core pipeline asks for a lock with a line address and a flag that says whether the access crosses a line boundary. For an access that stays within one line, the unit records that line in one lock register. From then on it holds back every coherence snoop that targets that line, so the line stays exclusively owned until the core sends unlock. Snoops to any other line continue without delay.

An access that spans two lines cannot be protected this way. For such an access the unit raises a global memory lock request and grants the core once the interconnect answers. Snoops that were held are kept in a small first-in first-out queue and released in arrival order as soon as the lock ends. A lock request for a line that is not already owned gets a "not ready" answer, so the core can first obtain ownership and then try again. A second lock request while a lock is active sets a sticky error flag.

Top module: `line_lock_unit`

## Requirements
- R1: A lock request with `lk_split`=0 and `lk_own`=1, made while no lock is active and no held snoop is waiting, raises `lk_grant` for exactly one cycle, in the cycle after the request. `lk_busy` is high from that cycle on.
- R2: While a single-line lock is active, a snoop whose address has the same line bits as the locked address produces no `snp_out_valid` until unlock.
- R3: While a lock is active, a snoop to any other line is accepted and appears on `snp_out_*` in the cycle after it is accepted.
- R4: A lock request with `lk_split`=1 raises `glk_req` in the next cycle. `glk_req` stays high until unlock. `lk_grant` pulses in the cycle after `glk_gnt` is seen. No line is held during such a lock, so snoops pass through.
- R5: A lock request with `lk_split`=0 and `lk_own`=0 pulses `lk_nrdy` in the next cycle and leaves `lk_busy` low.
- R6: Held snoops leave in the order they arrived, one per cycle, with the first one in the cycle after `ul_req`. While they drain, `snp_in_ready` is low.
- R7: At most 4 snoops are held. When 4 are held, `snp_in_ready` is low for another snoop to the locked line and high for a snoop to any other line.
- R8: A lock request while `lk_busy` is high sets `lk_err`, which stays high until reset. The request does not change the locked line.
- R9: `ul_req` during a lock drops `lk_busy` and `glk_req` in the next cycle. `ul_req` with no lock active has no effect.
- R10: A lock request made while held snoops are still draining gets `lk_nrdy` and is not granted.
- R11: Addresses are compared in whole 64-byte lines. Address bits [5:0] take no part in the locked-line comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lock request from the pipeline (one-cycle strobe) |
| lk_addr | input | ADDR_W | Address of the atomic access |
| lk_split | input | 1 | Access crosses a line boundary |
| lk_own | input | 1 | Line is held in an exclusive or modified state |
| ul_req | input | 1 | Unlock strobe: the atomic write has committed |
| lk_grant | output | 1 | One-cycle pulse: lock granted |
| lk_nrdy | output | 1 | One-cycle pulse: lock refused, retry later |
| lk_busy | output | 1 | A lock is active |
| lk_err | output | 1 | Sticky flag: lock requested while busy |
| glk_req | output | 1 | Global memory lock request |
| glk_gnt | input | 1 | Global memory lock grant |
| snp_in_valid | input | 1 | Incoming snoop valid |
| snp_in_ready | output | 1 | Incoming snoop accepted |
| snp_in_addr | input | ADDR_W | Snoop address |
| snp_in_kind | input | 1 | Snoop kind: 0 share, 1 take ownership |
| snp_out_valid | output | 1 | Snoop forwarded to the response path |
| snp_out_addr | output | ADDR_W | Forwarded snoop address |
| snp_out_kind | output | 1 | Forwarded snoop kind |

## Verification
If the lock register holds the wrong line, a snoop to the locked line shows up on `snp_out_valid` one cycle after it is accepted. A snoop to some other line, meanwhile, goes missing from the output. If the hold queue's pointers are corrupted, the order of the drained addresses after unlock is wrong, or the queue gives up backpressure one entry early or late. Each of these shows within a few cycles of the unlock. A faulty split-lock flag shows in the very next cycle, as `glk_req` low or a grant that never waits for `glk_gnt`.

// File: rtl/line_lock_pkg.sv
package line_lock_pkg;
    typedef enum logic {
        SNP_SHARE = 1'b0,
        SNP_TAKE  = 1'b1
    } snp_kind_e;
endpackage

// File: rtl/line_match.sv
module line_match #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 6
) (
    input  logic [ADDR_W-1:0]       addr,
    input  logic [ADDR_W-OFS_W-1:0] line,
    output logic                    hit
);
    // Byte-offset bits are dropped: whole-line comparison only
    assign hit = (addr[ADDR_W-1:OFS_W] == line);
endmodule

// File: rtl/snoop_hold_fifo.sv
module snoop_hold_fifo #(
    parameter int W     = 33,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULLC = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } ptr_t;

    ptr_t p_d, p_q;
    logic [W-1:0] mem_q [DEPTH];
    logic         do_push, do_pop;

    assign empty   = (p_q.cnt == '0);
    assign full    = (p_q.cnt == FULLC);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem_q[p_q.rd];

    always_comb begin
        p_d = p_q;
        if (do_push) p_d.wr = (p_q.wr == LAST) ? '0 : p_q.wr + 1'b1;
        if (do_pop)  p_d.rd = (p_q.rd == LAST) ? '0 : p_q.rd + 1'b1;
        case ({do_push, do_pop})
            2'b10:   p_d.cnt = p_q.cnt + 1'b1;
            2'b01:   p_d.cnt = p_q.cnt - 1'b1;
            default: p_d.cnt = p_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (do_push && p_q.wr == PTR_W'(i)) mem_q[i] <= din;
        end
    end
endmodule

// File: rtl/line_lock_unit.sv
module line_lock_unit
    import line_lock_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int HOLD_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              lk_split,
    input  logic              lk_own,
    input  logic              ul_req,
    output logic              lk_grant,
    output logic              lk_nrdy,
    output logic              lk_busy,
    output logic              lk_err,
    output logic              glk_req,
    input  logic              glk_gnt,
    input  logic              snp_in_valid,
    output logic              snp_in_ready,
    input  logic [ADDR_W-1:0] snp_in_addr,
    input  logic              snp_in_kind,
    output logic              snp_out_valid,
    output logic [ADDR_W-1:0] snp_out_addr,
    output logic              snp_out_kind
);
    localparam int OFS_W  = $clog2(LINE_BYTES);
    localparam int LINE_W = ADDR_W - OFS_W;
    localparam int SNP_W  = ADDR_W + 1;

    typedef struct packed {
        logic              active;
        logic              split;
        logic              wait_g;
        logic [LINE_W-1:0] line;
        logic              grant;
        logic              nrdy;
        logic              err;
        logic              glk;
        logic              out_v;
        logic [ADDR_W-1:0] out_addr;
        snp_kind_e         out_kind;
    } st_t;

    st_t d, q;

    logic             hit, hold, drain, accept, f_empty, f_full;
    logic [SNP_W-1:0] f_dout;
    logic [LINE_W-1:0] lock_line;

    line_match #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_match (
        .addr (snp_in_addr),
        .line (q.line),
        .hit  (hit)
    );

    // Held snoops are released once the lock is gone (or going this cycle)
    assign drain  = !f_empty && (!q.active || ul_req);
    assign hold   = q.active && !q.split && hit && !ul_req;
    assign snp_in_ready = !drain && !(hold && f_full);
    assign accept = snp_in_valid && snp_in_ready;

    snoop_hold_fifo #(.W(SNP_W), .DEPTH(HOLD_DEPTH)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (accept && hold),
        .pop   (drain),
        .din   ({snp_in_kind, snp_in_addr}),
        .dout  (f_dout),
        .empty (f_empty),
        .full  (f_full)
    );

    always_comb begin
        d       = q;
        d.grant = 1'b0;
        d.nrdy  = 1'b0;

        // Snoop output path
        d.out_v = 1'b0;
        if (drain) begin
            d.out_v    = 1'b1;
            d.out_addr = f_dout[ADDR_W-1:0];
            d.out_kind = snp_kind_e'(f_dout[ADDR_W]);
        end else if (accept && !hold) begin
            d.out_v    = 1'b1;
            d.out_addr = snp_in_addr;
            d.out_kind = snp_kind_e'(snp_in_kind);
        end

        // Lock ownership
        if (ul_req && q.active) begin
            d.active = 1'b0;
            d.split  = 1'b0;
            d.wait_g = 1'b0;
            d.glk    = 1'b0;
        end else begin
            if (q.wait_g && glk_gnt) begin
                d.wait_g = 1'b0;
                d.grant  = 1'b1;
            end
            if (lk_req) begin
                if (q.active) begin
                    d.err = 1'b1;
                end else if (!f_empty) begin
                    d.nrdy = 1'b1;
                end else if (lk_split) begin
                    d.active = 1'b1;
                    d.split  = 1'b1;
                    d.wait_g = 1'b1;
                    d.glk    = 1'b1;
                    d.line   = lk_addr[ADDR_W-1:OFS_W];
                end else if (lk_own) begin
                    d.active = 1'b1;
                    d.split  = 1'b0;
                    d.grant  = 1'b1;
                    d.line   = lk_addr[ADDR_W-1:OFS_W];
                end else begin
                    d.nrdy = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign lock_line     = q.line;
    assign lk_grant      = q.grant;
    assign lk_nrdy       = q.nrdy;
    assign lk_busy       = q.active;
    assign lk_err        = q.err;
    assign glk_req       = q.glk;
    assign snp_out_valid = q.out_v;
    assign snp_out_addr  = q.out_addr;
    assign snp_out_kind  = q.out_kind;
endmodule

module line_lock_chk #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 6
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    lk_req,
    input logic                    lk_split,
    input logic                    lk_own,
    input logic                    ul_req,
    input logic                    lk_grant,
    input logic                    lk_nrdy,
    input logic                    lk_busy,
    input logic                    lk_err,
    input logic                    glk_req,
    input logic                    snp_out_valid,
    input logic [ADDR_W-1:0]       snp_out_addr,
    input logic [ADDR_W-OFS_W-1:0] lock_line,
    input logic                    glk_mode
);
    AST_HELD_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_busy && $past(lk_busy) && !glk_mode && snp_out_valid)
            |-> (snp_out_addr[ADDR_W-1:OFS_W] != lock_line)); // R2
    AST_GRANT_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_grant && !glk_req) |-> $past(lk_req && lk_own)); // R1
    AST_GRANT_XOR_NRDY: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_grant && lk_nrdy)); // R5
    AST_GLK_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(glk_req) |-> $past(lk_req && lk_split)); // R4
    AST_GLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(glk_req) && !$past(ul_req)) |-> glk_req); // R4
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lk_err) |-> lk_err); // R8
    AST_UNLOCK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ul_req && lk_busy) |-> (!lk_busy && !glk_req)); // R9
endmodule

bind line_lock_unit line_lock_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .lk_req        (lk_req),
    .lk_split      (lk_split),
    .lk_own        (lk_own),
    .ul_req        (ul_req),
    .lk_grant      (lk_grant),
    .lk_nrdy       (lk_nrdy),
    .lk_busy       (lk_busy),
    .lk_err        (lk_err),
    .glk_req       (glk_req),
    .snp_out_valid (snp_out_valid),
    .snp_out_addr  (snp_out_addr),
    .lock_line     (lock_line),
    .glk_mode      (q.split)
);

// File: tb/tb_line_lock_unit.sv
module tb_line_lock_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 0, lk_split = 0, lk_own = 0, ul_req = 0, glk_gnt = 0;
    logic [31:0] lk_addr = '0;
    logic        snp_in_valid = 0, snp_in_kind = 0;
    logic [31:0] snp_in_addr = '0;
    logic        lk_grant, lk_nrdy, lk_busy, lk_err, glk_req, snp_in_ready;
    logic        snp_out_valid, snp_out_kind;
    logic [31:0] snp_out_addr;

    int errors = 0, checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    line_lock_unit dut (.*);

    // {held, address}: snoops issued while line 0x10000040 is locked
    localparam logic [32:0] VEC [8] = '{
        {1'b1, 32'h1000_0040}, {1'b0, 32'h1000_0080},
        {1'b1, 32'h1000_007F}, {1'b0, 32'h0000_0040},
        {1'b0, 32'h1000_0000}, {1'b1, 32'h1000_0065},
        {1'b0, 32'h2000_0040}, {1'b1, 32'h1000_0041}
    };

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        #1;
        chk(!lk_busy && !glk_req && !lk_err && !snp_out_valid, "reset R9", {lk_busy, glk_req, lk_err, snp_out_valid}, 0);
        chk(snp_in_ready, "reset ready R7", snp_in_ready, 1);

        // R5: not owned
        cyc(); lk_req = 1; lk_addr = 32'h1000_0040; lk_own = 0;
        cyc(); lk_req = 0;
        chk(lk_nrdy && !lk_grant && !lk_busy, "R5 nrdy", {lk_nrdy, lk_grant, lk_busy}, 3'b100);

        // R1: local lock
        lk_req = 1; lk_own = 1;
        cyc(); lk_req = 0; lk_own = 0;
        chk(lk_grant && lk_busy && !glk_req, "R1 grant", {lk_grant, lk_busy, glk_req}, 3'b110);
        cyc();
        chk(!lk_grant && lk_busy, "R1 pulse", {lk_grant, lk_busy}, 2'b01);

        // Table walk: R2, R3, R11
        foreach (VEC[i]) begin
            snp_in_valid = 1; snp_in_addr = VEC[i][31:0]; snp_in_kind = i[0];
            #1 chk(snp_in_ready, "R7 ready below full", snp_in_ready, 1);
            cyc(); snp_in_valid = 0;
            if (VEC[i][32]) begin
                chk(!snp_out_valid, "R2/R11 held", snp_out_valid, 0);
            end else begin
                chk(snp_out_valid && snp_out_addr == VEC[i][31:0] && snp_out_kind == i[0],
                    "R3 pass", snp_out_addr, VEC[i][31:0]);
            end
            cyc();
        end

        // R7: fifth snoop to locked line refused, other line still accepted
        snp_in_addr = 32'h1000_0050; #1;
        chk(!snp_in_ready, "R7 full locked line", snp_in_ready, 0);
        snp_in_addr = 32'h3000_0000; #1;
        chk(snp_in_ready, "R7 full other line", snp_in_ready, 1);

        // R8: second lock request
        cyc(); lk_req = 1; lk_addr = 32'h3000_0000; lk_own = 1;
        cyc(); lk_req = 0; lk_own = 0;
        chk(lk_err && !lk_grant && lk_busy, "R8 err", {lk_err, lk_grant, lk_busy}, 3'b101);
        snp_in_addr = 32'h1000_0040; #1;
        chk(!snp_in_ready, "R8 line kept", snp_in_ready, 0);

        // R6: unlock and drain
        cyc(); ul_req = 1; #1;
        chk(!snp_in_ready, "R6 ready low at unlock", snp_in_ready, 0);
        cyc(); ul_req = 0;
        chk(!lk_busy && snp_out_valid && snp_out_addr == 32'h1000_0040 && snp_out_kind == 1'b0,
            "R6 first", snp_out_addr, 32'h1000_0040);
        lk_req = 1; lk_own = 1; lk_addr = 32'h4000_0000;   // R10 during drain
        cyc(); lk_req = 0; lk_own = 0;
        chk(snp_out_valid && snp_out_addr == 32'h1000_007F && snp_out_kind == 1'b0, "R6 second", snp_out_addr, 32'h1000_007F);
        chk(lk_nrdy && !lk_busy, "R10 nrdy during drain", {lk_nrdy, lk_busy}, 2'b10);
        cyc();
        chk(snp_out_valid && snp_out_addr == 32'h1000_0065 && snp_out_kind == 1'b1, "R6 third", snp_out_addr, 32'h1000_0065);
        cyc();
        chk(snp_out_valid && snp_out_addr == 32'h1000_0041 && snp_out_kind == 1'b1, "R6 fourth", snp_out_addr, 32'h1000_0041);
        cyc();
        chk(!snp_out_valid && snp_in_ready, "R6 drained", {snp_out_valid, snp_in_ready}, 2'b01);
        chk(lk_err, "R8 sticky", lk_err, 1);

        // R9: unlock with nothing locked
        ul_req = 1;
        cyc(); ul_req = 0;
        chk(!lk_busy && !glk_req && !snp_out_valid, "R9 idle unlock", {lk_busy, glk_req}, 0);

        // R4: split lock
        lk_req = 1; lk_split = 1; lk_addr = 32'h1000_0040;
        cyc(); lk_req = 0; lk_split = 0;
        chk(glk_req && lk_busy && !lk_grant, "R4 glk raised", {glk_req, lk_busy, lk_grant}, 3'b110);
        repeat (3) cyc();
        chk(glk_req && !lk_grant, "R4 wait gnt", {glk_req, lk_grant}, 2'b10);
        snp_in_valid = 1; snp_in_addr = 32'h1000_0040; snp_in_kind = 1;
        cyc(); snp_in_valid = 0;
        chk(snp_out_valid && snp_out_addr == 32'h1000_0040, "R4 no line hold", snp_out_valid, 1);
        glk_gnt = 1;
        cyc(); glk_gnt = 0;
        chk(lk_grant && glk_req, "R4 grant", {lk_grant, glk_req}, 2'b11);
        cyc();
        chk(!lk_grant && glk_req, "R4 grant pulse", {lk_grant, glk_req}, 2'b01);
        ul_req = 1;
        cyc(); ul_req = 0;
        chk(!glk_req && !lk_busy, "R9 unlock drops", {glk_req, lk_busy}, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule